// File: doc/BRIEF.md
# Reset-Emulating Resetless Delay Line

This block delays a multi-bit data bus by a fixed number of clock cycles. Most of the storage is a plain shift chain with no reset, the kind of structure that maps onto lookup-table shift primitives. A synchronous, active-high reset is still honoured. Seen from the ports, the block behaves exactly like a chain of registers that are all cleared to zero, even though the resetless stages keep whatever data they held before the reset.

The reset is emulated by three pieces of resettable logic. A single-bit validity chain runs alongside the resetless core and marks which core stages hold data sampled since the last reset. The last two delay stages are taken out of the core and built as resettable registers. A per-bit select in front of them feeds zero until a valid sample reaches the end of the core.

The structure only pays off for a bus of two or more bits, and only when the core is longer than a minimum length. For a one-bit bus, or for a short delay, an elaboration-time choice builds an ordinary fully resettable register chain instead.

Top module: `dl_delay_line`

## Requirements
- R1: A sample presented on `data_i` in a cycle where `srst_i` is low appears on `data_o` exactly DEPTH rising edges later, provided no reset edge falls in between. The defaults are DEPTH = 4 and WIDTH = 18.
- R2: After any rising edge at which `srst_i` is high, `data_o` is all zeros. The sample presented on `data_i` in that cycle never appears on `data_o`.
- R3: After reset is released, `data_o` stays all zeros until the first sample taken after the release has travelled the full DEPTH stages. After that it carries data, exactly as a DEPTH-stage chain cleared to zero would.
- R4: A reset asserted for one cycle or for several consecutive cycles behaves the same way, including a reset that arrives again before the first post-reset sample has reached the output.
- R5: Data held in the resetless core when reset arrives never appears on `data_o`, even when every core stage holds nonzero data.
- R6: With WIDTH = 1 the block is built as a fully resettable register chain, and its port behaviour is identical to R1 to R3.
- R7: When DEPTH - 2 does not exceed CORE_MIN_LEN (default 3), the block is built as a fully resettable register chain, and its port behaviour is identical to R1 to R3. With the default CORE_MIN_LEN, DEPTH = 6 is the shortest delay that uses the split structure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| srst_i | input | 1 | Synchronous reset, active high |
| data_i | input | WIDTH | Data sampled on every rising edge |
| data_o | output | WIDTH | Data delayed by DEPTH cycles, zero after reset |

## Verification
The delicate case is a reset that lands while the validity chain is only partly filled. In that cycle the reset clearing and the first post-reset sample moving toward the select compete in the same edge. The bench provokes this with reset pulses spaced closer together than DEPTH, after the core has been filled with nonzero data. At each falling edge it compares every configured instance against a bench model of a fully cleared DEPTH-stage chain, so any stale word or early release shows up as a miscompare.

// File: rtl/dl_pkg.sv
package dl_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // Stages pulled out of the resetless core into resettable registers.
   localparam int DL_TAIL_STAGES = 2;

   // Chooses the split (resetless core) structure over a plain chain.
   function automatic bit dl_use_split(input int depth, input int width,
                                       input int core_min);
      return (width >= 2) && ((depth - DL_TAIL_STAGES) > core_min);
   endfunction

endpackage

// File: rtl/dl_plain_chain.sv
module dl_plain_chain #(
   parameter int DEPTH = 4,
   parameter int WIDTH = 18
) (
   input  logic             clk_i,
   input  logic             srst_i,
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] data_o
);
   timeunit 1ns;
   timeprecision 1ps;

   for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      logic [WIDTH-1:0] q;
      if (s == 0) begin : g_head
         always_ff @(posedge clk_i) begin
            if (srst_i) q <= '0;
            else        q <= data_i;
         end
      end else begin : g_body
         always_ff @(posedge clk_i) begin
            if (srst_i) q <= '0;
            else        q <= g_stage[s-1].q;
         end
      end
   end

   assign data_o = g_stage[DEPTH-1].q;

endmodule

// File: rtl/dl_bare_core.sv
module dl_bare_core #(
   parameter int LEN   = 6,
   parameter int WIDTH = 18
) (
   input  logic             clk_i,
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] data_o
);
   timeunit 1ns;
   timeprecision 1ps;

   // Plain shift stages: no reset, contents survive a reset of the block.
   for (genvar s = 0; s < LEN; s++) begin : g_stage
      logic [WIDTH-1:0] q;
      if (s == 0) begin : g_head
         always_ff @(posedge clk_i) q <= data_i;
      end else begin : g_body
         always_ff @(posedge clk_i) q <= g_stage[s-1].q;
      end
   end

   assign data_o = g_stage[LEN-1].q;

endmodule

// File: rtl/dl_valid_chain.sv
module dl_valid_chain #(
   parameter int LEN = 6
) (
   input  logic clk_i,
   input  logic srst_i,
   output logic valid_o
);
   timeunit 1ns;
   timeprecision 1ps;

   // Flag s is set when core stage s holds a sample taken after reset.
   for (genvar s = 0; s < LEN; s++) begin : g_flag
      logic q;
      if (s == 0) begin : g_head
         always_ff @(posedge clk_i) begin
            if (srst_i) q <= 1'b0;
            else        q <= 1'b1;
         end
      end else begin : g_body
         always_ff @(posedge clk_i) begin
            if (srst_i) q <= 1'b0;
            else        q <= g_flag[s-1].q;
         end
      end
   end

   assign valid_o = g_flag[LEN-1].q;

endmodule

// File: rtl/dl_tail.sv
module dl_tail #(
   parameter int WIDTH = 18
) (
   input  logic             clk_i,
   input  logic             srst_i,
   input  logic             valid_i,
   input  logic [WIDTH-1:0] core_i,
   output logic [WIDTH-1:0] data_o
);
   timeunit 1ns;
   timeprecision 1ps;

   // Per bit: substitution select, then two resettable stages.
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic pick;
      logic near_q;
      logic far_q;

      assign pick = valid_i & core_i[b];

      always_ff @(posedge clk_i) begin
         if (srst_i) begin
            near_q <= 1'b0;
            far_q  <= 1'b0;
         end else begin
            near_q <= pick;
            far_q  <= near_q;
         end
      end

      assign data_o[b] = far_q;
   end

endmodule

// File: rtl/dl_delay_line.sv
module dl_delay_line #(
   parameter int DEPTH        = 4,
   parameter int WIDTH        = 18,
   parameter int CORE_MIN_LEN = 3
) (
   input  logic             clk_i,
   input  logic             srst_i,
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] data_o
);
   timeunit 1ns;
   timeprecision 1ps;
   import dl_pkg::*;

   localparam bit USE_SPLIT = dl_use_split(DEPTH, WIDTH, CORE_MIN_LEN);
   localparam int CORE_LEN  = USE_SPLIT ? (DEPTH - DL_TAIL_STAGES) : 1;

   if (DEPTH < 1) begin : g_bad_depth
      $fatal(1, "dl_delay_line: DEPTH must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $fatal(1, "dl_delay_line: WIDTH must be at least 1");
   end
   if (CORE_MIN_LEN < 1) begin : g_bad_min
      $fatal(1, "dl_delay_line: CORE_MIN_LEN must be at least 1");
   end

   if (USE_SPLIT) begin : g_split
      logic [WIDTH-1:0] core_q;
      logic             core_valid;

      dl_bare_core #(.LEN(CORE_LEN), .WIDTH(WIDTH)) u_core (
         .clk_i  (clk_i),
         .data_i (data_i),
         .data_o (core_q)
      );

      dl_valid_chain #(.LEN(CORE_LEN)) u_valid (
         .clk_i   (clk_i),
         .srst_i  (srst_i),
         .valid_o (core_valid)
      );

      dl_tail #(.WIDTH(WIDTH)) u_tail (
         .clk_i   (clk_i),
         .srst_i  (srst_i),
         .valid_i (core_valid),
         .core_i  (core_q),
         .data_o  (data_o)
      );
   end else begin : g_plain
      dl_plain_chain #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chain (
         .clk_i  (clk_i),
         .srst_i (srst_i),
         .data_i (data_i),
         .data_o (data_o)
      );
   end

endmodule

// File: rtl/dl_delay_line_chk.sv
module dl_delay_line_chk #(
   parameter int DEPTH = 4,
   parameter int WIDTH = 18
) (
   input logic             clk_i,
   input logic             srst_i,
   input logic [WIDTH-1:0] data_i,
   input logic [WIDTH-1:0] data_o
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int CW = $clog2(DEPTH + 1) + 1;
   localparam logic [CW-1:0] LIM = CW'(DEPTH);

   logic             seen     = 1'b0;   // a reset edge has occurred
   logic [CW-1:0]    since    = '0;     // edges since release, saturating
   logic [CW-1:0]    run      = '0;     // equal consecutive samples, saturating
   logic [WIDTH-1:0] last_in  = '0;

   always_ff @(posedge clk_i) begin
      last_in <= data_i;
      if (srst_i) begin
         seen  <= 1'b1;
         since <= '0;
         run   <= '0;
      end else begin
         if (since != LIM) since <= since + 1'b1;
         if (run != '0 && data_i == last_in) begin
            if (run != LIM) run <= run + 1'b1;
         end else begin
            run <= CW'(1);
         end
      end
   end

   // R2: output clear after any reset edge
   a_r2_reset_clears: assert property (@(posedge clk_i) disable iff (!seen)
      srst_i |=> data_o == '0);

   // R3: nothing but zero until the first post-reset sample arrives
   a_r3_hidden_window: assert property (@(posedge clk_i) disable iff (srst_i || !seen)
      (since < LIM) |-> data_o == '0);

   // R1: a value held for DEPTH samples is what the output shows
   a_r1_steady_delay: assert property (@(posedge clk_i) disable iff (srst_i || !seen)
      (run >= LIM) |-> data_o == last_in);

   // R4: on release of any reset pulse the output is still zero
   a_r4_release_zero: assert property (@(posedge clk_i) disable iff (!seen)
      $fell(srst_i) |-> data_o == '0);

   // R5: no unknown value ever leaks out of the resetless core
   a_r5_no_unknown: assert property (@(posedge clk_i) disable iff (!seen)
      !$isunknown(data_o));

endmodule

bind dl_delay_line dl_delay_line_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
   .clk_i  (clk_i),
   .srst_i (srst_i),
   .data_i (data_i),
   .data_o (data_o)
);

// File: tb/tb_dl_delay_line.sv
module tb_dl_delay_line;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int MAXD = 12;

   logic        clk = 1'b0;
   logic        rst = 1'b0;
   logic [17:0] din = '0;

   logic [17:0] q_main;    // DEPTH 8,  WIDTH 18: split
   logic [17:0] q_short;   // DEPTH 4,  WIDTH 18: plain (defaults)
   logic [0:0]  q_narrow;  // DEPTH 8,  WIDTH 1 : plain
   logic [4:0]  q_long;    // DEPTH 12, WIDTH 5 : split
   logic [2:0]  q_edge;    // DEPTH 6,  WIDTH 3 : split, shortest
   logic [2:0]  q_five;    // DEPTH 5,  WIDTH 3 : plain, core too short

   always #5 clk = ~clk;

   dl_delay_line #(.DEPTH(8), .WIDTH(18)) dut (
      .clk_i(clk), .srst_i(rst), .data_i(din), .data_o(q_main));
   dl_delay_line dut_short (
      .clk_i(clk), .srst_i(rst), .data_i(din), .data_o(q_short));
   dl_delay_line #(.DEPTH(8), .WIDTH(1)) dut_narrow (
      .clk_i(clk), .srst_i(rst), .data_i(din[0:0]), .data_o(q_narrow));
   dl_delay_line #(.DEPTH(12), .WIDTH(5)) dut_long (
      .clk_i(clk), .srst_i(rst), .data_i(din[4:0]), .data_o(q_long));
   dl_delay_line #(.DEPTH(6), .WIDTH(3)) dut_edge (
      .clk_i(clk), .srst_i(rst), .data_i(din[2:0]), .data_o(q_edge));
   dl_delay_line #(.DEPTH(5), .WIDTH(3)) dut_five (
      .clk_i(clk), .srst_i(rst), .data_i(din[2:0]), .data_o(q_five));

   // Reference: a fully resettable chain; ref_q[k] is the output of stage k.
   logic [17:0] ref_q [1:MAXD];
   int    vectors    = 0;
   int    miscompares = 0;
   bit    done       = 1'b0;
   string phase      = "R2";

   initial for (int k = 1; k <= MAXD; k++) ref_q[k] = '0;

   task automatic cmp(input string tag, input string name,
                      input logic [17:0] act, input logic [17:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, name, act, exp, $time);
      end
   endtask

   task automatic check_all();
      cmp(phase, "main",   q_main,                ref_q[8]);
      cmp("R7",  "short",  q_short,               ref_q[4]);
      cmp("R6",  "narrow", {17'b0, q_narrow},     ref_q[8]  & 18'h00001);
      cmp(phase, "long",   {13'b0, q_long},       ref_q[12] & 18'h0001f);
      cmp(phase, "edge",   {15'b0, q_edge},       ref_q[6]  & 18'h00007);
      cmp("R7",  "five",   {15'b0, q_five},       ref_q[5]  & 18'h00007);
   endtask

   task automatic cycle(input logic r, input logic [17:0] d);
      rst = r;
      din = d;
      @(posedge clk);
      if (r) begin
         for (int k = 1; k <= MAXD; k++) ref_q[k] = '0;
      end else begin
         for (int k = MAXD; k > 1; k--) ref_q[k] = ref_q[k-1];
         ref_q[1] = d;
      end
      @(negedge clk);
      check_all();
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      logic [17:0] v;
      void'($urandom(32'd20240611));
      @(negedge clk);

      // R2: reset state, input during reset discarded
      phase = "R2";
      for (int i = 0; i < 3; i++) cycle(1'b1, 18'h3ffff);

      // R1: directed hold, then random stream with repeats
      phase = "R1";
      for (int i = 0; i < 15; i++) cycle(1'b0, 18'h2a5a5);
      v = '0;
      for (int i = 0; i < 60; i++) begin
         if ($urandom % 4 != 0) v = 18'($urandom);
         cycle(1'b0, v);
      end

      // R5: fill with nonzero data, then reset mid-stream
      phase = "R5";
      for (int i = 0; i < 20; i++) cycle(1'b0, 18'($urandom) | 18'h00007);
      cycle(1'b1, 18'h3ffff);
      // R3: zero window after release, then data
      phase = "R3";
      for (int i = 0; i < 16; i++) cycle(1'b0, 18'($urandom) | 18'h00001);

      // R4: pulses closer together than DEPTH, single and multi-cycle
      phase = "R4";
      for (int i = 0; i < 14; i++) cycle(1'b0, 18'h3ffff);
      cycle(1'b1, 18'h15555);
      for (int i = 0; i < 3; i++) cycle(1'b0, 18'h3ffff);
      cycle(1'b1, 18'h0aaaa);
      for (int i = 0; i < 5; i++) cycle(1'b0, 18'h3ffff);
      cycle(1'b1, 18'h3ffff);
      cycle(1'b1, 18'h3ffff);
      for (int i = 0; i < 7; i++) cycle(1'b0, 18'($urandom) | 18'h00001);
      cycle(1'b1, 18'h3ffff);
      for (int i = 0; i < 16; i++) cycle(1'b0, 18'($urandom));

      // R1: long random mix with occasional resets
      phase = "R1";
      for (int i = 0; i < 3000; i++) begin
         if ($urandom % 3 == 0) v = 18'($urandom);
         cycle(($urandom % 50) == 0, v);
      end

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

endmodule